// File: doc/BRIEF.md
# Controller FIFO Pair with Threshold Interrupts

This block sits between the bus sequencer of a two-wire serial controller and its register interface. It holds two 64-entry first-in-first-out queues: a transmit queue of command words, filled by software and drained by the sequencer, and a receive queue of data bytes, filled by the sequencer and drained by software. Both queues are show-ahead: the entry at the head is always visible on the pop-data port, and a pop request moves past it at the next clock edge.

Each queue counts its own misuse. A pop from an empty queue and a push into a full queue set sticky error flags instead of being silently dropped. One control write can empty either queue, clear that queue's error flags and load the two occupancy thresholds, all at the same time. Five interrupt sources feed a latch that is cleared by writing 1s. An enable mask lets a source through to the masked status and the single interrupt line. The transmit almost-empty source has its own clear strobe, separate from the shared one.

Top module: `fifo_irq_hub`

## Requirements
- R1: After reset the status word is 0x008: receive-empty (bit 3) is set, and both error pairs and transmit-full (bit 11) are clear. Masked interrupt status is 0 and `irq` is low.
- R2: The receive queue returns bytes in push order. The head entry is on `rxPopData` before the pop edge, and status bit 3 (receive empty) is set exactly when the queue holds no entry.
- R3: After 64 pushes with no pops, status bit 11 (transmit full) is set. A further push with no pop in the same cycle sets status bit 7 (transmit write error), and its data is dropped.
- R4: A pop from an empty queue sets that queue's read-error flag: bit 0 for receive, bit 6 for transmit. The flag stays set until that queue is cleared.
- R5: A control write with bit 0 set empties the receive queue and clears bits 0 and 1. Bit 1 does the same for the transmit queue and bits 6 and 7. Bits [7:2] load the receive threshold and bits [13:8] the transmit threshold. All of this takes effect at the write edge. The thresholds reset to 60 (receive) and 1 (transmit).
- R6: The interrupt bits are: 0 for the transfer-done event, 1 for the transfer-error event, 2 for any queue error flag, 3 for receive occupancy at or above its threshold, and 4 for transmit occupancy at or below its threshold. A source is latched at the first edge after it is seen. A set and a clear in the same cycle leave the bit set.
- R7: `intStatus` is the latched vector ANDed with the mask, where a mask bit of 1 enables the source. The mask resets to 0, and masking a source does not discard its latched value.
- R8: Writing 1s through the shared clear port clears latched bits 0 to 3. Its bit 4 has no effect.
- R9: A write of bit 0 = 1 through the dedicated transmit almost-empty clear port clears latched bit 4.
- R10: `irq` is high exactly when any bit of `intStatus` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txPushValid | input | 1 | Push a command word into the transmit queue |
| txPushData | input | CMD_W | Command word to push |
| txPopReq | input | 1 | Sequencer takes the transmit head entry |
| txPopData | output | CMD_W | Transmit head entry |
| rxPushValid | input | 1 | Sequencer pushes a received byte |
| rxPushData | input | RX_W | Received byte |
| rxPopReq | input | 1 | Software takes the receive head entry |
| rxPopData | output | RX_W | Receive head entry |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlWrData | input | 14 | Control word: clears and thresholds |
| intClrWrEn | input | 1 | Shared interrupt clear strobe |
| intClrWrData | input | 5 | Write-1-to-clear bits |
| intMaskWrEn | input | 1 | Mask write strobe |
| intMaskWrData | input | 5 | New mask, 1 enables a source |
| txAeClrWrEn | input | 1 | Dedicated transmit almost-empty clear strobe |
| txAeClrWrData | input | 1 | Bit 0 = 1 clears latched bit 4 |
| xferDoneEvt | input | 1 | Transfer-done event pulse |
| xferErrEvt | input | 1 | Transfer-error event pulse |
| fifoStatus | output | 12 | Queue status word |
| intStatus | output | 5 | Masked interrupt status |
| irq | output | 1 | Interrupt line |

## Verification
Queue status and head data change at the edge that performs the push, pop or clear, so the bench samples them just after that edge. Threshold and error interrupts are latched one edge later than the occupancy or flag that causes them, and the bench checks such a bit both at the first edge, where it must still be low, and at the second. Event pulses, mask writes and clears show up on `intStatus` right after their own edge. The bench drives every input and makes every check a short delay after a rising edge.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int INT_N    = 5;
  localparam int INT_DONE = 0;
  localparam int INT_XERR = 1;
  localparam int INT_FERR = 2;
  localparam int INT_RXAF = 3;
  localparam int INT_TXAE = 4;
  localparam int THR_W    = 6;
  localparam int CTRL_W   = 2 + 2 * THR_W;
  localparam int STAT_W   = 12;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic             rxClr;
    logic             txClr;
    logic [THR_W-1:0] rxThr;
    logic [THR_W-1:0] txThr;
  } fifoCtlT;

  // conditions from datapath back to control
  typedef struct packed {
    logic rxRdErr;
    logic rxWrErr;
    logic txRdErr;
    logic txWrErr;
    logic rxAlmostFull;
    logic txAlmostEmpty;
  } fifoFlagsT;
endpackage

// File: rtl/fifo_core.sv
module fifo_core #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clr,
  input  logic                     push,
  input  logic [WIDTH-1:0]         pushData,
  input  logic                     pop,
  output logic [WIDTH-1:0]         popData,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     rdErr,
  output logic                     wrErr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic isFull, isEmpty, doPush, doPop;

  assign isFull  = (count == CNT_W'(DEPTH));
  assign isEmpty = (count == '0);
  assign doPop   = pop && !isEmpty;
  // a full queue accepts a push when the head leaves in the same cycle
  assign doPush  = push && (!isFull || doPop);
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      rdErr <= 1'b0;
      wrErr <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop && isEmpty) rdErr <= 1'b1;
      if (push && !doPush) wrErr <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_irq_dpath.sv
module fifo_irq_dpath
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CMD_W = 11,
  parameter int RX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtlT           ctl,
  input  logic              txPushValid,
  input  logic [CMD_W-1:0]  txPushData,
  input  logic              txPopReq,
  output logic [CMD_W-1:0]  txPopData,
  input  logic              rxPushValid,
  input  logic [RX_W-1:0]   rxPushData,
  input  logic              rxPopReq,
  output logic [RX_W-1:0]   rxPopData,
  output fifoFlagsT         flags,
  output logic [STAT_W-1:0] status
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [CNT_W-1:0] txCount, rxCount;
  logic txRdErr, txWrErr, rxRdErr, rxWrErr;

  fifo_core #(.WIDTH(CMD_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .clr(ctl.txClr),
    .push(txPushValid), .pushData(txPushData),
    .pop(txPopReq), .popData(txPopData),
    .count(txCount), .rdErr(txRdErr), .wrErr(txWrErr)
  );

  fifo_core #(.WIDTH(RX_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .clr(ctl.rxClr),
    .push(rxPushValid), .pushData(rxPushData),
    .pop(rxPopReq), .popData(rxPopData),
    .count(rxCount), .rdErr(rxRdErr), .wrErr(rxWrErr)
  );

  always_comb begin
    flags.rxRdErr       = rxRdErr;
    flags.rxWrErr       = rxWrErr;
    flags.txRdErr       = txRdErr;
    flags.txWrErr       = txWrErr;
    flags.rxAlmostFull  = (rxCount >= CNT_W'(ctl.rxThr));
    flags.txAlmostEmpty = (txCount <= CNT_W'(ctl.txThr));
  end

  // bit positions are decoded by software
  always_comb begin
    status     = '0;
    status[0]  = rxRdErr;
    status[1]  = rxWrErr;
    status[3]  = (rxCount == '0);
    status[6]  = txRdErr;
    status[7]  = txWrErr;
    status[11] = (txCount == CNT_W'(DEPTH));
  end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int RX_AF_INIT = 60,
  parameter int TX_AE_INIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              intClrWrEn,
  input  logic [INT_N-1:0]  intClrWrData,
  input  logic              intMaskWrEn,
  input  logic [INT_N-1:0]  intMaskWrData,
  input  logic              txAeClrWrEn,
  input  logic              txAeClrWrData,
  input  logic              xferDoneEvt,
  input  logic              xferErrEvt,
  input  fifoFlagsT         flags,
  output fifoCtlT           ctl,
  output logic [INT_N-1:0]  intStatus
);
  logic [THR_W-1:0] rxThrReg, txThrReg;
  logic [INT_N-1:0] maskReg, latchReg, setVec, clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxThrReg <= THR_W'(RX_AF_INIT);
      txThrReg <= THR_W'(TX_AE_INIT);
      maskReg  <= '0;
    end else begin
      if (ctrlWrEn) begin
        rxThrReg <= ctrlWrData[2 +: THR_W];
        txThrReg <= ctrlWrData[2 + THR_W +: THR_W];
      end
      if (intMaskWrEn) maskReg <= intMaskWrData;
    end
  end

  always_comb begin
    ctl.rxClr = ctrlWrEn && ctrlWrData[0];
    ctl.txClr = ctrlWrEn && ctrlWrData[1];
    ctl.rxThr = rxThrReg;
    ctl.txThr = txThrReg;
  end

  always_comb begin
    setVec           = '0;
    setVec[INT_DONE] = xferDoneEvt;
    setVec[INT_XERR] = xferErrEvt;
    setVec[INT_FERR] = flags.rxRdErr | flags.rxWrErr | flags.txRdErr | flags.txWrErr;
    setVec[INT_RXAF] = flags.rxAlmostFull;
    setVec[INT_TXAE] = flags.txAlmostEmpty;
  end

  for (genvar i = 0; i < INT_N; i++) begin : gIntBit
    if (i == INT_TXAE) begin : gOwnClr
      assign clrVec[i] = txAeClrWrEn && txAeClrWrData;
    end else begin : gSharedClr
      assign clrVec[i] = intClrWrEn && intClrWrData[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN)          latchReg[i] <= 1'b0;
      else if (setVec[i]) latchReg[i] <= 1'b1;
      else if (clrVec[i]) latchReg[i] <= 1'b0;
    end
  end

  assign intStatus = latchReg & maskReg;
endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int CMD_W      = 11,
  parameter int RX_W       = 8,
  parameter int RX_AF_INIT = 60,
  parameter int TX_AE_INIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txPushValid,
  input  logic [CMD_W-1:0]  txPushData,
  input  logic              txPopReq,
  output logic [CMD_W-1:0]  txPopData,
  input  logic              rxPushValid,
  input  logic [RX_W-1:0]   rxPushData,
  input  logic              rxPopReq,
  output logic [RX_W-1:0]   rxPopData,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              intClrWrEn,
  input  logic [INT_N-1:0]  intClrWrData,
  input  logic              intMaskWrEn,
  input  logic [INT_N-1:0]  intMaskWrData,
  input  logic              txAeClrWrEn,
  input  logic              txAeClrWrData,
  input  logic              xferDoneEvt,
  input  logic              xferErrEvt,
  output logic [STAT_W-1:0] fifoStatus,
  output logic [INT_N-1:0]  intStatus,
  output logic              irq
);
  fifoCtlT   ctl;
  fifoFlagsT flags;

  fifo_irq_ctrl #(.RX_AF_INIT(RX_AF_INIT), .TX_AE_INIT(TX_AE_INIT)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .intClrWrEn(intClrWrEn), .intClrWrData(intClrWrData),
    .intMaskWrEn(intMaskWrEn), .intMaskWrData(intMaskWrData),
    .txAeClrWrEn(txAeClrWrEn), .txAeClrWrData(txAeClrWrData),
    .xferDoneEvt(xferDoneEvt), .xferErrEvt(xferErrEvt),
    .flags(flags), .ctl(ctl), .intStatus(intStatus)
  );

  fifo_irq_dpath #(.DEPTH(DEPTH), .CMD_W(CMD_W), .RX_W(RX_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .txPushValid(txPushValid), .txPushData(txPushData),
    .txPopReq(txPopReq), .txPopData(txPopData),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData),
    .rxPopReq(rxPopReq), .rxPopData(rxPopData),
    .flags(flags), .status(fifoStatus)
  );

  assign irq = |intStatus;
endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txPushValid,
  input logic       txPopReq,
  input logic       rxPopReq,
  input logic       rxClrReq,
  input logic       txClrReq,
  input logic       intClrBit4,
  input logic       intClrWrEn,
  input logic       intMaskWrEn,
  input logic [4:0] intMaskWrData,
  input logic       txAeClrWrEn,
  input logic       stRxRdErr,
  input logic       stRxWrErr,
  input logic       stRxEmpty,
  input logic       stTxRdErr,
  input logic       stTxWrErr,
  input logic       stTxFull,
  input logic [4:0] intStatus
);
  // R3
  tx_overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPushValid && stTxFull && !txPopReq && !txClrReq) |=> stTxWrErr);

  // R4
  rx_underflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPopReq && stRxEmpty && !rxClrReq) |=> stRxRdErr);

  // R4
  tx_rderr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stTxRdErr && !txClrReq) |=> stTxRdErr);

  // R5
  rx_clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxClrReq |=> (stRxEmpty && !stRxRdErr && !stRxWrErr));

  // R7
  mask_all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intMaskWrEn && intMaskWrData == 5'b0) |=> (intStatus == 5'b0));

  // R8
  shared_clr_skips_txae_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[4] && intClrWrEn && intClrBit4 && !txAeClrWrEn && !intMaskWrEn)
      |=> intStatus[4]);
endmodule

bind fifo_irq_hub fifo_irq_chk uChk (
  .clk(clk), .rstN(rstN),
  .txPushValid(txPushValid), .txPopReq(txPopReq), .rxPopReq(rxPopReq),
  .rxClrReq(ctrlWrEn && ctrlWrData[0]),
  .txClrReq(ctrlWrEn && ctrlWrData[1]),
  .intClrBit4(intClrWrData[4]), .intClrWrEn(intClrWrEn),
  .intMaskWrEn(intMaskWrEn), .intMaskWrData(intMaskWrData),
  .txAeClrWrEn(txAeClrWrEn),
  .stRxRdErr(fifoStatus[0]), .stRxWrErr(fifoStatus[1]), .stRxEmpty(fifoStatus[3]),
  .stTxRdErr(fifoStatus[6]), .stTxWrErr(fifoStatus[7]), .stTxFull(fifoStatus[11]),
  .intStatus(intStatus)
);

// File: tb/tb_fifo_irq_hub.sv
module tb_fifo_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_W = 11;
  localparam int RX_W  = 8;

  // fields: [18] push, [17] pop, [16:9] push byte, [8:1] expected head, [0] expected empty after
  localparam logic [18:0] RX_VEC [9] = '{
    {1'b1, 1'b0, 8'hA5, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h3C, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'hA5, 1'b0},
    {1'b1, 1'b0, 8'h77, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h3C, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h77, 1'b1},
    {1'b1, 1'b0, 8'h5A, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'h6B, 8'h5A, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'h6B, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txPushValid = 1'b0, txPopReq = 1'b0, rxPushValid = 1'b0, rxPopReq = 1'b0;
  logic [CMD_W-1:0] txPushData = '0;
  logic [RX_W-1:0]  rxPushData = '0;
  logic [CMD_W-1:0] txPopData;
  logic [RX_W-1:0]  rxPopData;
  logic ctrlWrEn = 1'b0, intClrWrEn = 1'b0, intMaskWrEn = 1'b0, txAeClrWrEn = 1'b0;
  logic [13:0] ctrlWrData = '0;
  logic [4:0]  intClrWrData = '0, intMaskWrData = '0;
  logic txAeClrWrData = 1'b0, xferDoneEvt = 1'b0, xferErrEvt = 1'b0;
  logic [11:0] fifoStatus;
  logic [4:0]  intStatus;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_irq_hub dut (
    .clk(clk), .rstN(rstN),
    .txPushValid(txPushValid), .txPushData(txPushData),
    .txPopReq(txPopReq), .txPopData(txPopData),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData),
    .rxPopReq(rxPopReq), .rxPopData(rxPopData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .intClrWrEn(intClrWrEn), .intClrWrData(intClrWrData),
    .intMaskWrEn(intMaskWrEn), .intMaskWrData(intMaskWrData),
    .txAeClrWrEn(txAeClrWrEn), .txAeClrWrData(txAeClrWrData),
    .xferDoneEvt(xferDoneEvt), .xferErrEvt(xferErrEvt),
    .fifoStatus(fifoStatus), .intStatus(intStatus), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctrlWrite(input logic [5:0] txThr, input logic [5:0] rxThr, input logic [1:0] clrs);
    ctrlWrEn = 1'b1;
    ctrlWrData = {txThr, rxThr, clrs};
    tick();
    ctrlWrEn = 1'b0;
  endtask

  task automatic maskWrite(input logic [4:0] m);
    intMaskWrEn = 1'b1;
    intMaskWrData = m;
    tick();
    intMaskWrEn = 1'b0;
  endtask

  task automatic sharedClear(input logic [4:0] c);
    intClrWrEn = 1'b1;
    intClrWrData = c;
    tick();
    intClrWrEn = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] d);
    rxPushValid = 1'b1;
    rxPushData = d;
    tick();
    rxPushValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 status", 32'(fifoStatus), 32'h008);
    check("R1 intStatus", 32'(intStatus), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2 table-driven receive order and empty flag
    for (int i = 0; i < 9; i++) begin
      rxPushValid = RX_VEC[i][18];
      rxPopReq    = RX_VEC[i][17];
      rxPushData  = RX_VEC[i][16:9];
      #1;
      if (RX_VEC[i][17]) check("R2 head data", 32'(rxPopData), 32'(RX_VEC[i][8:1]));
      tick();
      rxPushValid = 1'b0;
      rxPopReq = 1'b0;
      check("R2 rx empty", 32'(fifoStatus[3]), 32'(RX_VEC[i][0]));
    end
    check("R2 no rx errors", 32'(fifoStatus[1:0]), 32'h0);

    // R4 receive underflow, sticky
    rxPopReq = 1'b1;
    tick();
    rxPopReq = 1'b0;
    check("R4 rx read error", 32'(fifoStatus[0]), 32'h1);
    tick();
    check("R4 rx read error sticky", 32'(fifoStatus[0]), 32'h1);

    // R5 receive clear empties and drops its error flags
    rxPush(8'h12);
    ctrlWrite(6'd1, 6'd60, 2'b01);
    check("R5 rx clear", 32'(fifoStatus), 32'h008);

    // R3 fill the transmit queue
    for (int i = 0; i < 64; i++) begin
      txPushValid = 1'b1;
      txPushData = CMD_W'(i);
      tick();
      if (i == 62) check("R3 not full at 63", 32'(fifoStatus[11]), 32'h0);
    end
    txPushValid = 1'b0;
    check("R3 tx full", 32'(fifoStatus[11]), 32'h1);
    txPushValid = 1'b1;
    txPushData = 11'h7FF;
    tick();
    txPushValid = 1'b0;
    check("R3 tx write error", 32'(fifoStatus[7]), 32'h1);
    check("R3 still full", 32'(fifoStatus[11]), 32'h1);
    for (int i = 0; i < 64; i++) begin
      txPopReq = 1'b1;
      #1;
      check("R3 tx order, overflow dropped", 32'(txPopData), 32'(i));
      tick();
      txPopReq = 1'b0;
    end
    txPopReq = 1'b1;
    tick();
    txPopReq = 1'b0;
    check("R4 tx read error", 32'(fifoStatus[6]), 32'h1);

    // R6 R7 R10 queue-error interrupt
    maskWrite(5'b00100);
    check("R6 fifo error interrupt", 32'(intStatus), 32'h04);
    check("R10 irq high", 32'(irq), 32'h1);
    sharedClear(5'b00100);
    check("R6 set beats clear", 32'(intStatus[2]), 32'h1);
    ctrlWrite(6'd1, 6'd60, 2'b10);
    check("R5 tx clear", 32'(fifoStatus & 12'hCC0), 32'h0);
    sharedClear(5'b00100);
    check("R8 shared clear bit2", 32'(intStatus), 32'h0);
    check("R10 irq low", 32'(irq), 32'h0);

    // R5 R6 receive threshold 3
    ctrlWrite(6'd1, 6'd3, 2'b00);
    maskWrite(5'b01000);
    rxPush(8'h01);
    rxPush(8'h02);
    tick();
    check("R6 below rx threshold", 32'(intStatus[3]), 32'h0);
    rxPush(8'h03);
    check("R6 rx threshold one edge late", 32'(intStatus[3]), 32'h0);
    tick();
    check("R6 rx at threshold", 32'(intStatus[3]), 32'h1);

    // R8 R9 transmit almost-empty with its own clear
    txPushValid = 1'b1;
    txPushData = 11'h101;
    tick();
    txPushData = 11'h102;
    tick();
    txPushValid = 1'b0;
    tick();
    maskWrite(5'b10000);
    check("R6 tx almost-empty latched", 32'(intStatus), 32'h10);
    sharedClear(5'b10000);
    check("R8 shared clear ignores bit4", 32'(intStatus), 32'h10);
    txAeClrWrEn = 1'b1;
    txAeClrWrData = 1'b1;
    tick();
    txAeClrWrEn = 1'b0;
    txAeClrWrData = 1'b0;
    check("R9 dedicated clear", 32'(intStatus), 32'h0);
    txPopReq = 1'b1;
    tick();
    txPopReq = 1'b0;
    tick();
    check("R6 tx at threshold relatch", 32'(intStatus), 32'h10);

    // R6 R7 events
    maskWrite(5'b00001);
    xferDoneEvt = 1'b1;
    tick();
    xferDoneEvt = 1'b0;
    check("R6 done event", 32'(intStatus), 32'h01);
    sharedClear(5'b00001);
    check("R8 clear done", 32'(intStatus), 32'h0);
    xferErrEvt = 1'b1;
    tick();
    xferErrEvt = 1'b0;
    check("R7 masked error event", 32'(intStatus), 32'h0);
    check("R10 irq masked", 32'(irq), 32'h0);
    maskWrite(5'b00010);
    check("R7 latched kept under mask", 32'(intStatus), 32'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule